// File: doc/BRIEF.md
# GPIO port interrupt controller

This block controls one GPIO port of `N_PINS` pins (eight by default) through a byte-wide synchronous register interface. Each pin can be driven as an output or sampled as an input. Every input pin can raise an interrupt. Software picks, per pin, level or edge sensitivity and the active polarity. A pin can also pass through a debounce filter before detection.

Inputs first go through a two-flop synchroniser. Then an optional filter holds each pin until its value has been stable for `DB_SAMPLES` samples. After that, a detector either latches the chosen edge or passes the chosen level through. Latched edges stay pending until software writes a one to the pin's bit in the end-of-interrupt register. The pending bits, gated by the per-pin enable, form the status. The status drives one output line per pin and one combined line.

Register map, on a 4-bit address: 0 data, 1 direction, 2 mode, 3 polarity, 4 end-of-interrupt (write-only), 5 enable, 6 debounce enable, 7 status (read-only).

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe_o` is 0, the status is 0 and `irq_o` is low.
- R2: Direction (address 1) bit 1 makes a pin an output. For that pin, `pad_oe_o` is 1, and `pad_o` carries the data register (address 0). A data read returns the data register bit for output pins and the synchronised pad value for input pins.
- R3: With mode bit 1 (edge) and polarity bit 1, a rising pad transition latches the pin's pending bit. With polarity bit 0, a falling transition latches it. The opposite edge does not set it.
- R4: Writing a mask to the end-of-interrupt address (4) clears every latched pin whose mask bit is 1 and leaves the other latched pins set.
- R5: With mode bit 0 (level), the pending bit is 1 while the pad equals the polarity bit (1 high, 0 low) and 0 otherwise. It is not latched, and an end-of-interrupt write does not change it.
- R6: Status (address 7) is the pending bits ANDed with the enable register (address 5). Writing 0 to the enable silences every pin. An edge latched while disabled shows in the status once the pin is re-enabled.
- R7: With the debounce bit (address 6) set, a pad pulse shorter than `DB_SAMPLES` samples never reaches detection. A value held longer does reach it.
- R8: `irq_pin_o` equals the status, and `irq_o` is high exactly when any status bit is set.
- R9: Mode, polarity, enable, debounce and direction read back the value last written. Address 4 and addresses 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Read data for `addr_i`, combinational |
| pad_i | input | N_PINS | Pad input levels, asynchronous |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables |
| irq_pin_o | output | N_PINS | Per-pin interrupt lines |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The assertions assume that the filter's output only moves to a value the synchronised pin has shown on two successive samples. They also assume that a latched pin is released only by an end-of-interrupt bit, and is then cleared unless a new edge arrives in the same cycle. The bench drives `pad_i` only at falling clock edges and holds every level long enough to cross the synchroniser. It also changes mode and polarity only while the pads are quiet, so no reconfiguration creates an edge by itself. The debounce case uses a pulse two samples wide, well below the four-sample threshold.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA = 4'd0,
    A_DIR  = 4'd1,
    A_MODE = 4'd2,
    A_POL  = 4'd3,
    A_EOI  = 4'd4,
    A_IEN  = 4'd5,
    A_DBEN = 4'd6,
    A_STAT = 4'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
  parameter int DB_SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic smp_i,
  output logic flt_o
);
  localparam int RUN_W = (DB_SAMPLES > 2) ? $clog2(DB_SAMPLES) : 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DB_SAMPLES - 1);

  logic             last_q, filt_q;
  logic [RUN_W-1:0] run_q;

  // run_q counts consecutive equal sample pairs ending in last_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= 1'b0;
      run_q  <= '0;
      filt_q <= 1'b0;
    end else begin
      last_q <= smp_i;
      if (smp_i != last_q)    run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      if (!en_i)                 filt_q <= smp_i;
      else if (run_q == RUN_MAX) filt_q <= last_q;
    end
  end

  assign flt_o = en_i ? filt_q : smp_i;

  p_db_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && (filt_q != $past(filt_q))) |->
      ((filt_q == $past(smp_i, 2)) && ($past(smp_i, 2) == $past(smp_i, 3))));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] lvl_i,
  input  logic [N_PINS-1:0] mode_i,
  input  logic [N_PINS-1:0] pol_i,
  input  logic              eoi_we_i,
  input  logic [N_PINS-1:0] eoi_mask_i,
  output logic [N_PINS-1:0] pend_o
);
  logic [N_PINS-1:0] prev_q, latch_q;
  logic [N_PINS-1:0] rise_v, fall_v, hit_v, clr_v, keep_v;

  always_comb begin
    rise_v = lvl_i & ~prev_q;
    fall_v = ~lvl_i & prev_q;
    hit_v  = mode_i & ((pol_i & rise_v) | (~pol_i & fall_v));
    clr_v  = eoi_we_i ? eoi_mask_i : '0;
    keep_v = latch_q & mode_i & ~clr_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      latch_q <= keep_v | hit_v;
    end
  end

  // edge pins report the latch, level pins the live match
  assign pend_o = (mode_i & latch_q) | (~mode_i & ~(lvl_i ^ pol_i));

  p_set_needs_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(lvl_i ^ prev_q)) == '0));

  p_eoi_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_we_i |=> ((latch_q & $past(eoi_mask_i & ~hit_v)) == '0));

  p_latch_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & $past(keep_v)) == $past(keep_v)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int DB_SAMPLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pad_i,
  output logic [N_PINS-1:0] pad_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_PINS-1:0] irq_pin_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] data_q, dir_q, mode_q, pol_q, ien_q, dben_q;
  logic [N_PINS-1:0] smp_v, flt_v, pend_v, stat_v;
  logic              eoi_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
      dben_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_DATA:  data_q <= wdata_i;
        A_DIR:   dir_q  <= wdata_i;
        A_MODE:  mode_q <= wdata_i;
        A_POL:   pol_q  <= wdata_i;
        A_IEN:   ien_q  <= wdata_i;
        A_DBEN:  dben_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign eoi_we = we_i && (addr_i == A_EOI);

  gpio_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (smp_v)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    gpio_irq_debounce #(.DB_SAMPLES(DB_SAMPLES)) u_db (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (dben_q[p]),
      .smp_i (smp_v[p]),
      .flt_o (flt_v[p])
    );
  end

  gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (flt_v),
    .mode_i    (mode_q),
    .pol_i     (pol_q),
    .eoi_we_i  (eoi_we),
    .eoi_mask_i(wdata_i),
    .pend_o    (pend_v)
  );

  assign stat_v    = pend_v & ien_q;
  assign irq_pin_o = stat_v;
  assign irq_o     = |stat_v;
  assign pad_o     = data_q;
  assign pad_oe_o  = dir_q;

  always_comb begin
    case (addr_i)
      A_DATA:  rdata_o = (data_q & dir_q) | (smp_v & ~dir_q);
      A_DIR:   rdata_o = dir_q;
      A_MODE:  rdata_o = mode_q;
      A_POL:   rdata_o = pol_q;
      A_IEN:   rdata_o = ien_q;
      A_DBEN:  rdata_o = dben_q;
      A_STAT:  rdata_o = stat_v;
      default: rdata_o = '0;
    endcase
  end

  p_ien_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_IEN) && (wdata_i == '0)) |=> !irq_o);

  p_oe_follows_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_DIR)) |=> (pad_oe_o == $past(wdata_i)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int N = 8;
  localparam int NV = 12;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [3:0]   addr_i = '0;
  logic         we_i = 1'b0;
  logic [N-1:0] wdata_i = '0;
  logic [N-1:0] rdata_o;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] pad_o, pad_oe_o, irq_pin_o;
  logic         irq_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #2 clk_i = ~clk_i;

  gpio_irq_port u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .pad_i    (pad_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o),
    .irq_pin_o(irq_pin_o),
    .irq_o    (irq_o)
  );

  // {write addr, write data, read addr, expected read} (R9)
  localparam logic [23:0] VEC [NV] = '{
    {4'h2, 8'hA5, 4'h2, 8'hA5},
    {4'h3, 8'h3C, 4'h3, 8'h3C},
    {4'h5, 8'hF0, 4'h5, 8'hF0},
    {4'h6, 8'h0F, 4'h6, 8'h0F},
    {4'h1, 8'h81, 4'h1, 8'h81},
    {4'h4, 8'hFF, 4'h4, 8'h00},
    {4'h9, 8'h77, 4'h9, 8'h00},
    {4'h2, 8'h00, 4'h2, 8'h00},
    {4'h3, 8'h00, 4'h3, 8'h00},
    {4'h5, 8'h00, 4'h5, 8'h00},
    {4'h6, 8'h00, 4'h6, 8'h00},
    {4'h1, 8'h00, 4'h1, 8'h00}
  };

  task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [N-1:0] exp, input string tag);
    addr_i = a;
    #1;
    chk(rdata_o, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1 reset state
    rd(4'h1, 8'h00, "R1 dir");
    rd(4'h2, 8'h00, "R1 mode");
    rd(4'h7, 8'h00, "R1 status");
    chk(pad_oe_o, 8'h00, "R1 pad_oe");
    chk({7'd0, irq_o}, 8'h00, "R1 irq");

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:20], VEC[i][19:12]);
      rd(VEC[i][11:8], VEC[i][7:0], "R9 readback");
    end

    // R2 data and direction
    wr(4'h1, 8'h0F);
    wr(4'h0, 8'hA5);
    pad_i = 8'h30;
    idle(4);
    chk(pad_oe_o, 8'h0F, "R2 pad_oe");
    chk(pad_o, 8'hA5, "R2 pad_o");
    rd(4'h0, 8'h35, "R2 data read");
    wr(4'h1, 8'h00);
    pad_i = 8'h00;
    idle(4);

    // R3 edge latching
    wr(4'h3, 8'h0F);
    wr(4'h2, 8'hFF);
    wr(4'h5, 8'hFF);
    wr(4'h4, 8'hFF);
    idle(2);
    rd(4'h7, 8'h00, "R3 quiet");
    pad_i = 8'hFF;
    idle(6);
    rd(4'h7, 8'h0F, "R3 rising only");
    chk(irq_pin_o, 8'h0F, "R8 pin lines");
    chk({7'd0, irq_o}, 8'h01, "R8 combined high");
    pad_i = 8'h00;
    idle(6);
    rd(4'h7, 8'hFF, "R3 falling added");

    // R4 end of interrupt
    wr(4'h4, 8'h05);
    idle(1);
    rd(4'h7, 8'hFA, "R4 partial clear");
    wr(4'h4, 8'hFA);
    idle(1);
    rd(4'h7, 8'h00, "R4 full clear");
    chk({7'd0, irq_o}, 8'h00, "R8 combined low");

    // R6 enable gating
    wr(4'h5, 8'h00);
    pad_i = 8'h01;
    idle(6);
    rd(4'h7, 8'h00, "R6 gated");
    chk({7'd0, irq_o}, 8'h00, "R6 irq gated");
    wr(4'h5, 8'hFF);
    idle(1);
    rd(4'h7, 8'h01, "R6 retained");
    wr(4'h4, 8'h01);

    // R5 level mode
    wr(4'h2, 8'h00);
    idle(2);
    rd(4'h7, 8'hF1, "R5 level match");
    wr(4'h4, 8'hFF);
    idle(1);
    rd(4'h7, 8'hF1, "R5 eoi ignored");
    pad_i = 8'hF0;
    idle(6);
    rd(4'h7, 8'h00, "R5 level follows");

    // R7 debounce
    pad_i = 8'h00;
    idle(6);
    wr(4'h3, 8'hFF);
    wr(4'h2, 8'hFF);
    wr(4'h6, 8'h01);
    idle(8);
    wr(4'h4, 8'hFF);
    idle(1);
    rd(4'h7, 8'h00, "R7 start");
    pad_i = 8'h03;
    idle(2);
    pad_i = 8'h00;
    idle(10);
    rd(4'h7, 8'h02, "R7 short pulse filtered");
    pad_i = 8'h01;
    idle(12);
    rd(4'h7, 8'h03, "R7 held value passes");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule